// File: doc/BRIEF.md
# Write-Only Two-Wire Control Slave

This block is a receive-only slave on a two-wire serial bus (I2C-style). It lives in a system-clock domain: the bus clock and data lines are oversampled through synchronizers, and the block answers by pulling the data line low through an open-drain enable. Once it sees a start condition followed by its own write address, it acknowledges. It then accepts two don't-care bytes, a command byte and a count byte, and acknowledges both. After those, every further byte is written into a small bank of control registers. The writes always begin at the first register and move forward one register per byte.

The register bank drives one enable per clock output and a test-mode flag. The bus side has no read path and no sub-address, and the block never stretches the clock. To change a later register, a host must resend every byte before it. A read request or a foreign address makes the block go silent until the next start.

Top module: `ctl2w_wr_slave`

## Requirements
- R1: After reset, every bit of `clk_en_o` is 1, `test_mode_o` is 0 and `sda_oe_o` is 0.
- R2: A start (SDA falls while SCL is high) begins address matching. A stop (SDA rises while SCL is high) returns the block to idle. In idle, bytes clocked without a start are not acknowledged.
- R3: The address byte 0xD2 (7-bit address 0x69 with the write bit 0) is acknowledged: `sda_oe_o` is 1 while SCL is high in the ninth clock.
- R4: An address byte with the read bit set, or with any other address, is not acknowledged. The block then acknowledges nothing and changes no register until the next start.
- R5: The two bytes after an acknowledged address are acknowledged, and their contents have no effect on any register.
- R6: Later bytes are written to register 0, then register 1, and so on. Every transaction starts again at register 0, and registers that receive no byte keep their values.
- R7: Bits arrive most significant first. The first bit of a byte lands in bit 7 of the register.
- R8: Bytes beyond the last register (two registers by default) are acknowledged and discarded.
- R9: A register changes only when all 8 of its bits have been followed by the falling SCL edge of bit 8. If a stop arrives before that edge, the register keeps its value.
- R10: A repeated start, even with no stop before it, restarts address matching and restarts the register index at 0.
- R11: `sda_oe_o` is 0 while SCL is high during data bits 1 to 8. It rises only after the SCL fall that ends bit 8, and it returns to 0 after the SCL fall that ends bit 9.
- R12: Bits [4:0] of register 0 drive `clk_en_o[4:0]`, and bit 0 of register 1 drives `test_mode_o`. No other register bit reaches an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous to `clk` |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain) |
| clk_en_o | output | 5 | Per-output clock enable |
| test_mode_o | output | 1 | Test mode enable |

## Verification
Two actions share a single system-clock cycle: the register commit and the rise of the acknowledge drive. Both come from the SCL fall that ends bit 8. The bench samples the acknowledge in the ninth clock and then reads the resulting enable pattern at the ports. A stop and a commit can also compete for the same byte. To provoke this, the bench clocks eight bits of a data byte and raises SDA while SCL is still high, before the falling edge of bit 8. It then checks that no acknowledge was driven and that the enables still show the value from the earlier write.

// File: rtl/ctlslv_pkg.sv
// Package: shared types for the write-only two-wire control slave.
// Assumes nothing beyond the standard; holds only the protocol phase encoding.
package ctlslv_pkg;

    // Protocol phase of the slave within one bus transaction.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,  // waiting for a start condition
        PH_ADDR = 3'd1,  // receiving address + direction byte
        PH_CMD  = 3'd2,  // first don't-care byte
        PH_CNT  = 3'd3,  // second don't-care byte
        PH_DATA = 3'd4,  // register payload bytes
        PH_SKIP = 3'd5   // not addressed: silent until next start
    } phase_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ctlslv_sync.sv
// Module: ctlslv_sync
// Brings the asynchronous bus lines into the system clock domain through a
// STAGES-deep flop chain per line, then derives SCL edges and the start and
// stop conditions from the synchronized levels.
// Assumes the system clock oversamples SCL by well above 4x, and bus idle high.
module ctlslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;
    localparam int IDX_SCL = 0;
    localparam int IDX_SDA = 1;

    logic [NLINES-1:0] raw_w;
    logic [NLINES-1:0] lvl_w;
    logic [NLINES-1:0] prev_q;

    assign raw_w = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            // Shift one raw line through its synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], raw_w[g]};
                end
            end
            assign lvl_w[g] = chain_q[STAGES-1];
        end
    endgenerate

    // Keep the previous synchronized level of both lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= lvl_w;
        end
    end

    assign scl_lvl   = lvl_w[IDX_SCL];
    assign sda_lvl   = lvl_w[IDX_SDA];
    assign scl_rise  = lvl_w[IDX_SCL] & ~prev_q[IDX_SCL];
    assign scl_fall  = ~lvl_w[IDX_SCL] & prev_q[IDX_SCL];
    assign start_det = lvl_w[IDX_SCL] & prev_q[IDX_SCL] & prev_q[IDX_SDA] & ~lvl_w[IDX_SDA];
    assign stop_det  = lvl_w[IDX_SCL] & prev_q[IDX_SCL] & ~prev_q[IDX_SDA] & lvl_w[IDX_SDA];

endmodule

// File: rtl/ctlslv_fsm.sv
// Module: ctlslv_fsm
// Byte receiver and protocol sequencer. Shifts bits in on SCL rise, decides
// the acknowledge on the SCL fall ending bit 8 (and issues the register write
// in that same cycle), and releases the acknowledge on the fall ending bit 9.
// Assumes synchronized, single-cycle edge and condition strobes.
module ctlslv_fsm
    import ctlslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 2,
    parameter int         IDXW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              ack_oe,
    output logic              wr_en,
    output logic [IDXW-1:0]   wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [BYTE_W-1:0] WR_ADDR_BYTE = {DEV_ADDR, 1'b0};
    localparam logic [IDXW-1:0]   IDX_END      = IDXW'(NUM_REGS);
    localparam logic [3:0]        CNT_BIT8     = 4'd8;
    localparam logic [3:0]        CNT_ACK      = 4'd9;

    phase_t            phase_q, phase_d;
    logic [3:0]        bitcnt_q, bitcnt_d;
    logic [BYTE_W-1:0] shreg_q, shreg_d;
    logic [IDXW-1:0]   idx_q, idx_d;
    logic              ack_q, ack_d;

    // Next-state logic: conditions first, then SCL edges inside a byte.
    always_comb begin
        phase_d  = phase_q;
        bitcnt_d = bitcnt_q;
        shreg_d  = shreg_q;
        idx_d    = idx_q;
        ack_d    = ack_q;
        wr_en    = 1'b0;
        if (stop_det) begin
            phase_d  = PH_IDLE;
            bitcnt_d = '0;
            ack_d    = 1'b0;
        end else if (start_det) begin
            phase_d  = PH_ADDR;
            bitcnt_d = '0;
            ack_d    = 1'b0;
            idx_d    = '0;
        end else if (phase_q == PH_IDLE || phase_q == PH_SKIP) begin
            ack_d = 1'b0;
        end else if (scl_rise) begin
            if (bitcnt_q < CNT_BIT8) begin
                shreg_d  = {shreg_q[BYTE_W-2:0], sda_lvl};
                bitcnt_d = bitcnt_q + 4'd1;
            end
        end else if (scl_fall) begin
            if (bitcnt_q == CNT_BIT8) begin
                bitcnt_d = CNT_ACK;
                unique case (phase_q)
                    PH_ADDR: begin
                        if (shreg_q == WR_ADDR_BYTE) begin
                            ack_d = 1'b1;
                        end else begin
                            phase_d  = PH_SKIP;
                            bitcnt_d = '0;
                        end
                    end
                    PH_DATA: begin
                        ack_d = 1'b1;
                        if (idx_q < IDX_END) begin
                            wr_en = 1'b1;
                            idx_d = idx_q + 1'b1;
                        end
                    end
                    default: ack_d = 1'b1;
                endcase
            end else if (bitcnt_q == CNT_ACK) begin
                ack_d    = 1'b0;
                bitcnt_d = '0;
                unique case (phase_q)
                    PH_ADDR: phase_d = PH_CMD;
                    PH_CMD:  phase_d = PH_CNT;
                    PH_CNT:  phase_d = PH_DATA;
                    default: phase_d = phase_q;
                endcase
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            idx_q    <= '0;
            ack_q    <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            bitcnt_q <= bitcnt_d;
            shreg_q  <= shreg_d;
            idx_q    <= idx_d;
            ack_q    <= ack_d;
        end
    end

    assign ack_oe  = ack_q;
    assign wr_idx  = idx_q;
    assign wr_data = shreg_q;

    // R11: the acknowledge drive only starts while SCL is low.
    p_ack_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> !scl_lvl);

    // R4: an unaddressed slave never drives the line.
    p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SKIP) |-> !ack_q);

    // R2: a start always lands in address matching with the line released.
    p_start_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det && !stop_det |=> (phase_q == PH_ADDR) && !ack_q);

    // R2: a stop always returns to idle.
    p_stop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (phase_q == PH_IDLE));

    // R11: the bit counter never leaves the nine-clock frame.
    p_bitcnt_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= CNT_ACK);

endmodule

// File: rtl/ctlslv_regbank.sv
// Module: ctlslv_regbank
// Bank of NUM_REGS byte-wide control registers written one at a time by index.
// Assumes the writer never presents an index at or above NUM_REGS.
module ctlslv_regbank
    import ctlslv_pkg::*;
#(
    parameter int                          NUM_REGS = 2,
    parameter int                          IDXW     = 2,
    parameter logic [NUM_REGS*BYTE_W-1:0]  RST_VAL  = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDXW-1:0]              wr_idx,
    input  logic [BYTE_W-1:0]            wr_data,
    output logic [NUM_REGS*BYTE_W-1:0]   regs_o
);

    genvar k;
    generate
        for (k = 0; k < NUM_REGS; k++) begin : g_reg
            logic [BYTE_W-1:0] byte_q;
            // Load this register when the write index selects it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= RST_VAL[k*BYTE_W +: BYTE_W];
                end else if (wr_en && (wr_idx == IDXW'(k))) begin
                    byte_q <= wr_data;
                end
            end
            assign regs_o[k*BYTE_W +: BYTE_W] = byte_q;
        end
    endgenerate

    // R8: the sequencer never asks for a register that does not exist.
    p_idx_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDXW'(NUM_REGS)));

    // R9: without a write strobe the bank holds its contents.
    p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

endmodule

// File: rtl/ctl2w_wr_slave.sv
// Module: ctl2w_wr_slave (top)
// Write-only two-wire control slave: synchronizer, protocol sequencer and
// control register bank. Register 0 low bits drive the clock enables, one bit
// of register 1 drives test mode.
// Assumes NUM_CLK <= 8, NUM_REGS >= 2 and an external pull-up on the data line.
module ctl2w_wr_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_CLK     = 5,
    parameter int         NUM_REGS    = 2,
    parameter int         SYNC_STAGES = 2,
    parameter int         TEST_BIT    = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    output logic [NUM_CLK-1:0] clk_en_o,
    output logic               test_mode_o
);

    localparam int BW   = ctlslv_pkg::BYTE_W;
    localparam int IDXW = $clog2(NUM_REGS + 1);

    // Reset image: all clock enables set, everything else clear.
    function automatic logic [NUM_REGS*BW-1:0] reset_image();
        logic [NUM_REGS*BW-1:0] img;
        img = '0;
        img[NUM_CLK-1:0] = '1;
        return img;
    endfunction

    localparam logic [NUM_REGS*BW-1:0] RST_VAL = reset_image();

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [BW-1:0]   wr_data;
    logic [NUM_REGS*BW-1:0] ctrl_w;
    logic            unused_ctrl;

    ctlslv_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ctlslv_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .IDXW     (IDXW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    ctlslv_regbank #(
        .NUM_REGS (NUM_REGS),
        .IDXW     (IDXW),
        .RST_VAL  (RST_VAL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (ctrl_w)
    );

    assign clk_en_o    = ctrl_w[NUM_CLK-1:0];
    assign test_mode_o = ctrl_w[BW + TEST_BIT];
    assign unused_ctrl = ^ctrl_w;

    // R12: the enables follow register 0 one cycle after a write of it.
    p_enable_follows_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_idx == '0) |=> (clk_en_o == $past(wr_data[NUM_CLK-1:0])));

endmodule

// File: tb/ctl2w_wr_slave_tb.sv
// Bench for ctl2w_wr_slave: a vector table of whole transactions walked by one
// loop, then directed tests for reset, partial bytes, restarts and overflow.
module ctl2w_wr_slave_tb;

    localparam int Q = 6;       // system cycles per quarter SCL period
    localparam int NV = 7;

    // Fields: addr[63:56] cmd[55:48] cnt[47:40] d0[39:32] d1[31:24]
    // exp_en[23:16] ndata[15:12] exp_ack[8] exp_tm[0]
    localparam logic [63:0] VEC [NV] = '{
        64'hD200000A010A_2101,   // R6 R12: both registers written
        64'hD255AA150015_1101,   // R6: only register 0, register 1 kept
        64'hD300000000_15_2001,  // R4: read bit set, ignored
        64'hA400000000_15_2001,  // R4: foreign address, ignored
        64'hD2FFFF1F001F_2100,   // R5: dummy bytes all ones have no effect
        64'hD20301E0FE00_2100,   // R12: unmapped bits do not reach outputs
        64'hD2000201_8001_2100   // R7: MSB first (LSB-first would differ)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [4:0] clk_en;
    logic test_mode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    ctl2w_wr_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .clk_en_o    (clk_en),
        .test_mode_o (test_mode)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_restart();
        sda_m = 1'b1; wait_cyc(Q);
        scl = 1'b1; wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b1; wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(2*Q);
    endtask

    // Clock one byte plus the ack slot; report ack and R11 timing observations.
    task automatic send_byte(input logic [7:0] b, output bit acked, output bit leak, output bit held);
        leak = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(Q);
            scl = 1'b1; wait_cyc(Q);
            if (sda_oe) leak = 1'b1;
            wait_cyc(Q);
            scl = 1'b0; wait_cyc(Q);
        end
        sda_m = 1'b1; wait_cyc(Q);
        scl = 1'b1; wait_cyc(Q);
        acked = sda_oe;
        wait_cyc(Q);
        scl = 1'b0; wait_cyc(Q);
        held = sda_oe;
    endtask

    task automatic xfer(input logic [7:0] b, input bit exp_ack, input string tag);
        bit a, l, h;
        send_byte(b, a, l, h);
        check(a == exp_ack, tag, 32'(a), 32'(exp_ack));
        check(!l && !h, "R11", {30'd0, l, h}, 32'd0);
    endtask

    task automatic check_outputs(input logic [4:0] en, input bit tm, input string tag);
        check(clk_en == en, tag, 32'(clk_en), 32'(en));
        check(test_mode == tm, tag, 32'(test_mode), 32'(tm));
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin : main
        logic [63:0] e;
        bit a, l, h;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
        // R1: reset state
        check_outputs(5'h1F, 1'b0, "R1");
        check(sda_oe == 1'b0, "R1", 32'(sda_oe), 32'd0);

        // Table walk: one transaction per vector, outputs checked after stop.
        for (int v = 0; v < NV; v++) begin
            e = VEC[v];
            bus_start();
            xfer(e[63:56], e[8], "R3");
            xfer(e[55:48], e[8], "R5");
            xfer(e[47:40], e[8], "R5");
            for (int k = 0; k < int'(e[15:12]); k++) begin
                xfer(k == 0 ? e[39:32] : e[31:24], e[8], "R6");
            end
            bus_stop();
            check_outputs(e[20:16], e[0], "R6");
        end

        // R8: bytes past the last register are acknowledged and dropped.
        bus_start();
        xfer(8'hD2, 1'b1, "R3");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h03, 1'b1, "R6");
        xfer(8'h01, 1'b1, "R6");
        xfer(8'h1C, 1'b1, "R8");
        xfer(8'h1C, 1'b1, "R8");
        bus_stop();
        check_outputs(5'h03, 1'b1, "R8");

        // R9: eight rises of a byte then stop before bit-8 falling edge.
        bus_start();
        xfer(8'hD2, 1'b1, "R3");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h00, 1'b1, "R5");
        for (int i = 7; i >= 1; i--) begin
            sda_m = (i == 4); wait_cyc(Q);
            scl = 1'b1; wait_cyc(2*Q);
            check(sda_oe == 1'b0, "R9", 32'(sda_oe), 32'd0);
            scl = 1'b0; wait_cyc(Q);
        end
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b1; wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(2*Q);
        check(sda_oe == 1'b0, "R9", 32'(sda_oe), 32'd0);
        check_outputs(5'h03, 1'b1, "R9");

        // R2: a byte clocked in idle with no start is not acknowledged.
        send_byte(8'hD2, a, l, h);
        check(a == 1'b0, "R2", 32'(a), 32'd0);
        bus_stop();
        check_outputs(5'h03, 1'b1, "R2");

        // R10 with R4: foreign address, repeated start, write, repeated start again.
        bus_start();
        xfer(8'hA4, 1'b0, "R4");
        bus_restart();
        xfer(8'hD2, 1'b1, "R10");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h11, 1'b1, "R6");
        bus_restart();
        xfer(8'hD2, 1'b1, "R10");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h0C, 1'b1, "R10");
        xfer(8'h00, 1'b1, "R10");
        bus_stop();
        check_outputs(5'h0C, 1'b0, "R10");

        // R1: reset in mid-run restores the reset image.
        bus_start();
        xfer(8'hD2, 1'b1, "R3");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h00, 1'b1, "R5");
        xfer(8'h02, 1'b1, "R6");
        xfer(8'h01, 1'b1, "R6");
        bus_stop();
        check_outputs(5'h02, 1'b1, "R12");
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        check_outputs(5'h1F, 1'b0, "R1");
        check(sda_oe == 1'b0, "R1", 32'(sda_oe), 32'd0);

        done = 1'b1;
        finish_up();
    end

endmodule